// File: doc/BRIEF.md
# Dual-Compare Timer Output Generator

This block runs an up-counter against two compare registers, A and B, and drives a single timer output pin. Each compare channel has a 2-bit action field that says what happens to the output level on its match. The choices are hold, force low, force high or invert. When both channels match on the same edge, the actions are merged by a fixed precedence.

Software-side access is a simple synchronous write port plus a combinational read port. Four registers are reachable this way: the counter, the two compare values and a control register that holds the action fields. Counting advances only on cycles where the tick-enable input is high. That input stands in for any prescaler.

Top module: `dual_match_timer`

## Requirements
- R1: The counter increments by one on each clock edge where `tickEn` is high and no counter write occurs, and holds otherwise.
- R2: Control bits 1:0 choose the compare-A action and bits 3:2 the compare-B action. Code 00 holds the level, 01 drives it to 0, 10 drives it to 1 and 11 inverts it.
- R3: On a same-edge match of A and B, invert wins over drive-high, and drive-high wins over drive-low. A hold code never overrides the other channel's action.
- R4: While all four action bits are 0, `timerOut` is 0. The internal level is kept, and once an action code is nonzero again, `timerOut` shows that kept level.
- R5: After reset, `timerOut` is 0 until a match changes it. The counter is 0x00, both compare registers are 0xFF and the control register reads 0x10.
- R6: Bit 4 of the control register always reads 1 and ignores writes. Bits 7:5 always read 0.
- R7: The counter wraps from 0xFF to 0x00 on an enabled tick.
- R8: A counter write on the same edge as an enabled tick loads the written value, and the increment is lost.
- R9: A match takes effect only on an edge where `tickEn` is high and the counter equals the compare value. An idle counter sitting on the compare value causes no action.
- R10: The register addresses are 0 for the counter, 1 for compare A, 2 for compare B and 3 for control. `rdData` reflects `rdAddr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count enable for this cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write register address |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read register address |
| rdData | output | 8 | Read data |
| timerOut | output | 1 | Timer output pin |

## Verification
Two events can land on the same edge: the compare-A match and the compare-B match. The bench provokes this by loading both compare registers with the current counter value and then issuing one tick. It does this for all sixteen pairs of action codes, from both a low and a high starting level. Each result is judged against an expected level computed from the precedence rule. A second collision is a counter write on the same edge as a tick, and it is judged by reading the counter back.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_FLIP = 2'b11
  } act_e;

  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_CMPA = 2'd1;
  localparam logic [1:0] ADDR_CMPB = 2'd2;
  localparam logic [1:0] ADDR_CTL  = 2'd3;

  typedef struct packed {
    logic ldCnt;
    logic ldCmpA;
    logic ldCmpB;
    logic ldCtl;
    logic inc;
    logic drvLow;
    logic drvHigh;
    logic flip;
  } strobe_t;
endpackage

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dmt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmpA,
  input  logic [CNT_W-1:0] cmpB,
  input  logic [SEL_W-1:0] sel,
  output strobe_t          stb
);
  localparam int FIELD_W = SEL_W / 2;

  logic matchA, matchB;
  act_e actA, actB, winAct;

  always_comb begin
    matchA = tickEn && (cnt == cmpA);
    matchB = tickEn && (cnt == cmpB);
    actA   = matchA ? act_e'(sel[FIELD_W-1:0]) : ACT_KEEP;
    actB   = matchB ? act_e'(sel[SEL_W-1:FIELD_W]) : ACT_KEEP;
    // codes are ordered so that the larger one is the stronger action
    winAct = (actA > actB) ? actA : actB;
  end

  always_comb begin
    stb         = '0;
    stb.ldCnt   = wrEn && (wrAddr == ADDR_CNT);
    stb.ldCmpA  = wrEn && (wrAddr == ADDR_CMPA);
    stb.ldCmpB  = wrEn && (wrAddr == ADDR_CMPB);
    stb.ldCtl   = wrEn && (wrAddr == ADDR_CTL);
    stb.inc     = tickEn;
    stb.flip    = (winAct == ACT_FLIP);
    stb.drvHigh = (winAct == ACT_HIGH);
    stb.drvLow  = (winAct == ACT_LOW);
  end
endmodule

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dmt_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cmpA,
  output logic [CNT_W-1:0] cmpB,
  output logic [SEL_W-1:0] sel,
  output logic             outLevel,
  output logic             timerOut
);
  localparam int FIXED_BIT = SEL_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.ldCnt) begin
      cnt <= wrData;
    end else if (stb.inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpA <= '1;
      cmpB <= '1;
      sel  <= '0;
    end else begin
      if (stb.ldCmpA) cmpA <= wrData;
      if (stb.ldCmpB) cmpB <= wrData;
      if (stb.ldCtl)  sel  <= wrData[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLevel <= 1'b0;
    end else if (stb.flip) begin
      outLevel <= ~outLevel;
    end else if (stb.drvHigh) begin
      outLevel <= 1'b1;
    end else if (stb.drvLow) begin
      outLevel <= 1'b0;
    end
  end

  assign timerOut = (|sel) & outLevel;

  logic [CNT_W-1:0] ctlView;
  always_comb begin
    ctlView              = '0;
    ctlView[FIXED_BIT]   = 1'b1;
    ctlView[SEL_W-1:0]   = sel;
    unique case (rdAddr)
      ADDR_CNT:  rdData = cnt;
      ADDR_CMPA: rdData = cmpA;
      ADDR_CMPB: rdData = cmpB;
      default:   rdData = ctlView;
    endcase
  end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
  import dmt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       rdAddr,
  output logic [CNT_W-1:0] rdData,
  output logic             timerOut
);
  localparam int SEL_W = 4;

  strobe_t          stb;
  logic [CNT_W-1:0] cnt, cmpA, cmpB;
  logic [SEL_W-1:0] sel;
  logic             outLevel;

  dmt_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) uCtrl (
    .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB), .sel(sel), .stb(stb)
  );

  dmt_datapath #(.CNT_W(CNT_W), .SEL_W(SEL_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .cnt(cnt), .cmpA(cmpA),
    .cmpB(cmpB), .sel(sel), .outLevel(outLevel), .timerOut(timerOut)
  );
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             wrEn,
  input logic [1:0]       wrAddr,
  input logic [CNT_W-1:0] wrData,
  input logic [1:0]       rdAddr,
  input logic [CNT_W-1:0] rdData,
  input logic             timerOut,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmpA,
  input logic [CNT_W-1:0] cmpB,
  input logic [3:0]       sel,
  input logic             outLevel
);
  a_r4_disabled_low: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 4'd0) |-> !timerOut);

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !(wrEn && wrAddr == 2'd0) && cnt == '1) |=> (cnt == '0));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 2'd0) |=> (cnt == $past(wrData)));

  a_r9_hold_without_match: assert property (@(posedge clk) disable iff (!rstN)
    !(tickEn && (cnt == cmpA || cnt == cmpB)) |=> $stable(outLevel));

  a_r3_flip_wins: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && cnt == cmpA && sel[1:0] == 2'b11) |=> (outLevel != $past(outLevel)));

  a_r6_fixed_bit: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == 2'd3) |-> (rdData[4] && rdData[7:5] == 3'b000));
endmodule

bind dual_match_timer dmt_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .timerOut(timerOut),
  .cnt(cnt), .cmpA(cmpA), .cmpB(cmpB), .sel(sel), .outLevel(outLevel)
);

// File: tb/dual_match_timer_test.sv
module dual_match_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [1:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       timerOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int mCnt, mA, mB, mSel, mOut;

  always #4 clk = ~clk;

  dual_match_timer uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .timerOut(timerOut)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int applyCode(input int code, input int lvl);
    if (code == 3) return 1 - lvl;
    if (code == 2) return 1;
    if (code == 1) return 0;
    return lvl;
  endfunction

  // one clock with the given inputs; model updated from the requirements
  task automatic step(input bit tk, input bit we, input int addr, input int data);
    int ca, cb, win;
    tickEn = tk; wrEn = we; wrAddr = addr[1:0]; wrData = data[7:0];
    @(posedge clk);
    ca  = (tk && mCnt == mA) ? (mSel & 3) : 0;
    cb  = (tk && mCnt == mB) ? ((mSel >> 2) & 3) : 0;
    win = (ca > cb) ? ca : cb;
    mOut = applyCode(win, mOut);
    if (we && addr == 1) mA = data;
    if (we && addr == 2) mB = data;
    if (we && addr == 3) mSel = data & 15;
    if (we && addr == 0) mCnt = data;
    else if (tk) mCnt = (mCnt + 1) % 256;
    #1;
    tickEn = 0; wrEn = 0;
  endtask

  task automatic readReg(input int addr, output int val);
    rdAddr = addr[1:0];
    #1;
    val = int'(rdData);
  endtask

  function automatic int expPin();
    return (mSel != 0) ? mOut : 0;
  endfunction

  task automatic setLevel(input int v);
    step(0, 1, 1, mCnt);
    step(0, 1, 3, v ? 2 : 1);
    step(1, 0, 0, 0);
  endtask

  initial begin
    #150000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    mCnt = 0; mA = 255; mB = 255; mSel = 0; mOut = 0;
    repeat (3) @(posedge clk);
    #1; rstN = 1;

    // R5 reset state, R10 address map
    check(timerOut == 0, "R5 pin after reset", timerOut, 0);
    readReg(0, v); check(v == 0, "R5 R10 counter reset", v, 0);
    readReg(1, v); check(v == 255, "R5 R10 cmpA reset", v, 255);
    readReg(2, v); check(v == 255, "R5 R10 cmpB reset", v, 255);
    readReg(3, v); check(v == 'h10, "R5 R10 ctl reset", v, 'h10);

    // R5 low until first match: invert armed on A at 0xFF, count 0..3
    step(0, 1, 3, 3);
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0);
    check(timerOut == 0, "R5 low before first match", timerOut, 0);

    // R6 fixed bit and reserved bits
    step(0, 1, 3, 'hEF);
    readReg(3, v); check(v == 'h1F, "R6 ctl write EF", v, 'h1F);
    step(0, 1, 3, 'h00);
    readReg(3, v); check(v == 'h10, "R6 ctl write 00", v, 'h10);

    // R1 increment and hold
    step(0, 1, 0, 'h20);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
    step(0, 0, 0, 0);
    readReg(0, v); check(v == 'h25, "R1 count five ticks", v, 'h25);

    // R7 wrap
    step(0, 1, 0, 'hFE);
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    readReg(0, v); check(v == 0, "R7 wrap to zero", v, 0);

    // R8 write beats tick
    step(1, 1, 0, 'h40);
    readReg(0, v); check(v == 'h40, "R8 write priority", v, 'h40);
    check(v == mCnt, "R8 model agrees", v, mCnt);

    // R9 idle counter on compare value: no action
    step(0, 1, 1, mCnt);
    step(0, 1, 3, 3);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0);
    check(timerOut == expPin(), "R9 no match while idle", timerOut, expPin());
    step(1, 0, 0, 0);
    check(timerOut == 1, "R9 match on enabled tick", timerOut, 1);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0);
    check(timerOut == 1, "R9 single pulse per pass", timerOut, 1);

    // R2 each channel alone, R10 cmpB address
    for (int ch = 0; ch < 2; ch++) begin
      for (int code = 1; code < 4; code++) begin
        for (int st = 0; st < 2; st++) begin
          int e;
          setLevel(st);
          step(0, 1, ch ? 2 : 1, mCnt);
          step(0, 1, ch ? 1 : 2, (mCnt + 100) % 256);
          step(0, 1, 3, ch ? (code << 2) : code);
          e = applyCode(code, st);
          step(1, 0, 0, 0);
          check(timerOut == e, "R2 single channel action", timerOut, e);
        end
      end
    end

    // R3 exhaustive same-edge collisions
    for (int sa = 0; sa < 4; sa++) begin
      for (int sb = 0; sb < 4; sb++) begin
        for (int st = 0; st < 2; st++) begin
          int e, w;
          setLevel(st);
          step(0, 1, 1, mCnt);
          step(0, 1, 2, mCnt);
          step(0, 1, 3, (sb << 2) | sa);
          step(1, 0, 0, 0);
          w = (sa > sb) ? sa : sb;
          e = ((sa | sb) != 0) ? applyCode(w, st) : 0;
          check(timerOut == e, "R3 collision precedence", timerOut, e);
          check(timerOut == expPin(), "R3 model agrees", timerOut, expPin());
        end
      end
    end

    // R4 disable keeps level and resumes
    setLevel(1);
    step(0, 1, 1, (mCnt + 50) % 256);
    step(0, 1, 3, 0);
    check(timerOut == 0, "R4 disabled pin low", timerOut, 0);
    step(1, 0, 0, 0); step(1, 0, 0, 0);
    step(0, 1, 3, 1);
    check(timerOut == 1, "R4 resume kept level", timerOut, 1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule